// File: doc/BRIEF.md
# Sized Load/Store Data Extender

This unit sits between a 32-bit register file and a byte-addressed, single-cycle synchronous data memory. It handles byte, halfword and word transfers in four addressing forms: register to register, register-indirect, register-indirect with post-increment of the base, and stack-relative with a 6-bit unsigned displacement scaled by the access size. It computes the effective address, steers store data onto the correct byte lanes with matching write strobes, and extracts and sign- or zero-extends narrow load data into a full 32-bit write-back value.

A request is presented for one cycle together with the register values it needs: base, source and stack pointer. The memory port is driven in that same cycle. The memory returns read data one clock later. Both the register write-back and the base-register update appear as one-cycle pulses two clock edges after the request. A new request may be issued in every cycle. Encodings used throughout: size 0 = byte, 1 = halfword, 2 or 3 = word; mode 0 = register move, 1 = indirect, 2 = indirect with post-increment, 3 = stack-relative. Memory byte lanes are little-endian: lane n of the data word holds the byte at address offset n.

Top module: `sized_xfer_unit`

## Requirements
- R1: A signed byte load returns the byte at lane addr[1:0] in wb_data[7:0], and every bit of wb_data[31:8] is a copy of its bit 7.
- R2: An unsigned byte load returns the addressed byte in wb_data[7:0], and wb_data[31:8] is zero.
- R3: A halfword load takes lanes {2*addr[1]+1, 2*addr[1]} and fills wb_data[31:16] with its bit 15 (signed) or with zero (unsigned). Halfword addresses are even.
- R4: Mode 0 moves req_src into wb_data through the same byte or halfword extension, without a memory access (mem_en stays low). In this mode req_store has no effect.
- R5: Word loads and word moves return all 32 bits unchanged, and req_unsigned has no effect on them. Word addresses are multiples of 4.
- R6: In mode 2 the access uses the old base, and upd_en pulses with upd_idx = req_base_idx and upd_data = base + 1, 2 or 4 for byte, halfword or word.
- R7: In mode 3 the address is req_sp + req_disp × (1, 2 or 4 by size), and no base update occurs.
- R8: In mode 1 the address is the base itself, and no base update occurs.
- R9: A store drives mem_wr, with mem_wstrb set to one lane for a byte, lanes 0-1 or 2-3 by addr[1] for a halfword, and all four lanes for a word. The source's low bits appear on every enabled lane, and memory bytes outside the strobe are unchanged.
- R10: A store never produces a write-back. A post-increment load whose destination index equals its base index writes back the loaded data and suppresses the base update.
- R11: wb_en and upd_en follow their request by exactly two clock edges, and back-to-back requests each produce their own results in order.
- R12: After reset, mem_en, mem_wr, mem_wstrb, wb_en and upd_en are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load (ignored in mode 0) |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_unsigned | input | 1 | Zero-extend narrow loads and moves |
| req_mode | input | 2 | 0 move, 1 indirect, 2 post-increment, 3 stack-relative |
| req_rd | input | IDX_W | Destination register index |
| req_base_idx | input | IDX_W | Base register index |
| req_base | input | ADDR_W | Base register value |
| req_src | input | 32 | Store data, or move source |
| req_sp | input | ADDR_W | Stack pointer value |
| req_disp | input | DISP_W | Unsigned stack displacement in access units |
| mem_en | output | 1 | Memory access this cycle |
| mem_wr | output | 1 | Memory write |
| mem_addr | output | ADDR_W | Byte address |
| mem_wstrb | output | 4 | Byte lane write strobes |
| mem_wdata | output | 32 | Lane-steered store data |
| mem_rdata | input | 32 | Read word, valid one cycle after the access |
| wb_en | output | 1 | Register write-back pulse |
| wb_idx | output | IDX_W | Write-back register index |
| wb_data | output | 32 | Extended write-back value |
| upd_en | output | 1 | Base update pulse |
| upd_idx | output | IDX_W | Base register index to update |
| upd_data | output | ADDR_W | Advanced base value |

## Verification
Wrong lane selection or a wrong extension shows at wb_data two edges after the load, either as a wrong low byte or halfword or as a wrong fill in the upper bits. A wrong size decode also shows in the same cycle as the request, as a wrong mem_wstrb or a wrong stack-scaled mem_addr. A stage register that loses or mixes context between back-to-back requests puts one request's index or data onto the next request's output slot, so the tests issue requests in consecutive cycles and check each slot. A failure in the post-increment conflict rule shows as an upd_en pulse in the same cycle as the write-back to the same index.

// File: rtl/sxu_pkg.sv
package sxu_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    MD_REG  = 2'd0,
    MD_IND  = 2'd1,
    MD_POST = 2'd2,
    MD_STK  = 2'd3
  } mode_e;

  // log2 of the access size in bytes
  function automatic logic [1:0] scale_of(size_e s);
    case (s)
      SZ_BYTE: return 2'd0;
      SZ_HALF: return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

  function automatic logic [2:0] step_of(size_e s);
    return 3'd1 << scale_of(s);
  endfunction

  function automatic logic [LANES-1:0] strobe_of(size_e s, logic [1:0] lo);
    case (s)
      SZ_BYTE: return LANES'(1) << lo;
      SZ_HALF: return lo[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] widen(logic [WORD_W-1:0] v, size_e s, logic uns);
    case (s)
      SZ_BYTE: return uns ? {24'h0, v[7:0]}  : {{24{v[7]}}, v[7:0]};
      SZ_HALF: return uns ? {16'h0, v[15:0]} : {{16{v[15]}}, v[15:0]};
      default: return v;
    endcase
  endfunction
endpackage

// File: rtl/sxu_agen.sv
module sxu_agen
  import sxu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  mode_e             mode,
  input  size_e             size,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] sp,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] next_base,
  output logic              post_evt
);
  logic [1:0]        sh;
  logic [ADDR_W-1:0] scaled;

  assign sh        = scale_of(size);
  assign scaled    = ADDR_W'(disp) << sh;
  assign addr      = (mode == MD_STK) ? (sp + scaled) : base;
  assign next_base = base + ADDR_W'(step_of(size));
  assign post_evt  = active && (mode == MD_POST);

  // halfword memory accesses stay on even addresses
  p_half_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && mode != MD_REG && size == SZ_HALF) |-> !addr[0]);

  // word memory accesses stay on 4-byte boundaries
  p_word_quad_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && mode != MD_REG && (size == SZ_WORD || size == SZ_WIDE)) |-> addr[1:0] == 2'b00);
endmodule

// File: rtl/sxu_lane.sv
module sxu_lane
  import sxu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  size_e             size,
  input  logic [1:0]        lo,
  input  logic [WORD_W-1:0] data,
  output logic [LANES-1:0]  strb,
  output logic [WORD_W-1:0] wdata
);
  assign strb = wr ? strobe_of(size, lo) : '0;

  always_comb begin
    case (size)
      SZ_BYTE: wdata = {LANES{data[7:0]}};
      SZ_HALF: wdata = {(LANES/2){data[15:0]}};
      default: wdata = data;
    endcase
  end

  p_byte_one_lane_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && size == SZ_BYTE) |-> ($countones(strb) == 1 && strb[lo]));

  p_half_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && size == SZ_HALF) |-> (strb == 4'b0011 || strb == 4'b1100));
endmodule

// File: rtl/sxu_extend.sv
module sxu_extend
  import sxu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk,
  input  logic [WORD_W-1:0] raw,
  input  logic [1:0]        lo,
  input  size_e             size,
  input  logic              uns,
  output logic [WORD_W-1:0] value
);
  logic [WORD_W-1:0] aligned;

  assign aligned = raw >> {lo, 3'b000};
  assign value   = widen(aligned, size, uns);

  p_byte_zero_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (chk && uns && size == SZ_BYTE) |-> value[31:8] == '0);

  p_byte_sign_fill_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (chk && !uns && size == SZ_BYTE) |-> value[31:8] == {24{value[7]}});

  p_half_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (chk && size == SZ_HALF) |-> value[31:16] == (uns ? 16'h0 : {16{value[15]}}));
endmodule

// File: rtl/sized_xfer_unit.sv
module sized_xfer_unit
  import sxu_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int ADDR_W = 32,
  parameter int DISP_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [1:0]        req_size,
  input  logic              req_unsigned,
  input  logic [1:0]        req_mode,
  input  logic [IDX_W-1:0]  req_rd,
  input  logic [IDX_W-1:0]  req_base_idx,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [31:0]       req_src,
  input  logic [ADDR_W-1:0] req_sp,
  input  logic [DISP_W-1:0] req_disp,
  output logic              mem_en,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_wstrb,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              wb_en,
  output logic [IDX_W-1:0]  wb_idx,
  output logic [31:0]       wb_data,
  output logic              upd_en,
  output logic [IDX_W-1:0]  upd_idx,
  output logic [ADDR_W-1:0] upd_data
);
  size_e size_d;
  mode_e mode_d;
  assign size_d = size_e'(req_size);
  assign mode_d = mode_e'(req_mode);

  // request classification
  logic is_move, is_load, is_store, upd_kill, upd_want;
  assign is_move  = req_valid && (mode_d == MD_REG);
  assign is_load  = req_valid && (mode_d != MD_REG) && !req_store;
  assign is_store = req_valid && (mode_d != MD_REG) && req_store;
  assign upd_kill = is_load && (req_rd == req_base_idx);

  logic [ADDR_W-1:0] ea, nxt;
  logic              post_evt;

  sxu_agen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_agen (
    .clk(clk), .rst_n(rst_n), .active(req_valid), .mode(mode_d), .size(size_d),
    .base(req_base), .sp(req_sp), .disp(req_disp),
    .addr(ea), .next_base(nxt), .post_evt(post_evt)
  );

  assign upd_want = post_evt && !upd_kill;

  logic [3:0]  lane_strb;
  logic [31:0] lane_data;

  sxu_lane u_lane (
    .clk(clk), .rst_n(rst_n), .wr(is_store), .size(size_d), .lo(ea[1:0]),
    .data(req_src), .strb(lane_strb), .wdata(lane_data)
  );

  assign mem_en    = is_load || is_store;
  assign mem_wr    = is_store;
  assign mem_addr  = ea;
  assign mem_wstrb = lane_strb;
  assign mem_wdata = lane_data;

  // stage 1: context held while memory returns data
  logic              s1_wb, s1_mv, s1_uns, s1_upd;
  size_e             s1_size;
  logic [1:0]        s1_lo;
  logic [IDX_W-1:0]  s1_rd, s1_bidx;
  logic [31:0]       s1_src;
  logic [ADDR_W-1:0] s1_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_wb   <= 1'b0;
      s1_mv   <= 1'b0;
      s1_uns  <= 1'b0;
      s1_upd  <= 1'b0;
      s1_size <= SZ_BYTE;
      s1_lo   <= '0;
      s1_rd   <= '0;
      s1_bidx <= '0;
      s1_src  <= '0;
      s1_next <= '0;
    end else begin
      s1_wb   <= is_move || is_load;
      s1_mv   <= is_move;
      s1_uns  <= req_unsigned;
      s1_upd  <= upd_want;
      s1_size <= size_d;
      s1_lo   <= ea[1:0];
      s1_rd   <= req_rd;
      s1_bidx <= req_base_idx;
      s1_src  <= req_src;
      s1_next <= nxt;
    end
  end

  logic [31:0] ext_raw, ext_val;
  logic [1:0]  ext_lo;
  assign ext_raw = s1_mv ? s1_src : mem_rdata;
  assign ext_lo  = s1_mv ? 2'b00 : s1_lo;

  sxu_extend u_ext (
    .clk(clk), .rst_n(rst_n), .chk(s1_wb), .raw(ext_raw), .lo(ext_lo),
    .size(s1_size), .uns(s1_uns), .value(ext_val)
  );

  // stage 2: registered results
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_en    <= 1'b0;
      wb_idx   <= '0;
      wb_data  <= '0;
      upd_en   <= 1'b0;
      upd_idx  <= '0;
      upd_data <= '0;
    end else begin
      wb_en    <= s1_wb;
      wb_idx   <= s1_rd;
      wb_data  <= ext_val;
      upd_en   <= s1_upd;
      upd_idx  <= s1_bidx;
      upd_data <= s1_next;
    end
  end

  p_move_no_mem_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == MD_REG) |-> !mem_en);

  p_wb_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !(req_mode != MD_REG && req_store)) |=> ##1 (wb_en && wb_idx == $past(req_rd, 2)));

  p_store_no_wb_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode != MD_REG && req_store) |=> ##1 !wb_en);

  p_conflict_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == MD_POST && !req_store && req_rd == req_base_idx) |=> ##1 (wb_en && !upd_en));

  p_post_upd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == MD_POST && (req_store || req_rd != req_base_idx))
      |=> ##1 (upd_en && upd_idx == $past(req_base_idx, 2)));

  p_no_upd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode != MD_POST) |=> ##1 !upd_en);

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!mem_en && !mem_wr && mem_wstrb == 4'b0000));
endmodule

// File: tb/sized_xfer_unit_bench.sv
module sized_xfer_unit_bench;
  localparam int IDX_W = 4;
  localparam int ADDR_W = 32;
  localparam int DISP_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic req_valid = 0, req_store = 0, req_unsigned = 0;
  logic [1:0] req_size = 0, req_mode = 0;
  logic [IDX_W-1:0] req_rd = 0, req_base_idx = 0;
  logic [ADDR_W-1:0] req_base = 0, req_sp = 0;
  logic [31:0] req_src = 0;
  logic [DISP_W-1:0] req_disp = 0;
  logic mem_en, mem_wr, wb_en, upd_en;
  logic [ADDR_W-1:0] mem_addr, upd_data;
  logic [3:0] mem_wstrb;
  logic [31:0] mem_wdata, wb_data;
  logic [31:0] mem_rdata = 0;
  logic [IDX_W-1:0] wb_idx, upd_idx;

  sized_xfer_unit #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_sized_xfer_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_unsigned(req_unsigned), .req_mode(req_mode),
    .req_rd(req_rd), .req_base_idx(req_base_idx), .req_base(req_base),
    .req_src(req_src), .req_sp(req_sp), .req_disp(req_disp),
    .mem_en(mem_en), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wstrb(mem_wstrb),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .wb_en(wb_en), .wb_idx(wb_idx),
    .wb_data(wb_data), .upd_en(upd_en), .upd_idx(upd_idx), .upd_data(upd_data)
  );

  // bench memory: 64 words, synchronous read, byte-lane writes
  logic [31:0] bmem [64];
  always @(posedge clk) begin
    if (mem_en) begin
      mem_rdata <= bmem[mem_addr[7:2]];
      if (mem_wr)
        for (int i = 0; i < 4; i++)
          if (mem_wstrb[i]) bmem[mem_addr[7:2]][i*8 +: 8] <= mem_wdata[i*8 +: 8];
    end
  end

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mb(logic [31:0] a);
    return bmem[a[7:2]][a[1:0]*8 +: 8];
  endfunction

  // bench's own view of a load result
  function automatic logic [31:0] want_load(logic [31:0] a, int sz, bit u);
    logic [15:0] h;
    if (sz == 0) return u ? 32'(mb(a)) : 32'($signed(mb(a)));
    if (sz == 1) begin
      h = {mb(a + 1), mb(a)};
      return u ? 32'(h) : 32'($signed(h));
    end
    return {mb(a + 3), mb(a + 2), mb(a + 1), mb(a)};
  endfunction

  function automatic logic [31:0] want_move(logic [31:0] v, int sz, bit u);
    if (sz == 0) return u ? 32'(v[7:0]) : 32'($signed(v[7:0]));
    if (sz == 1) return u ? 32'(v[15:0]) : 32'($signed(v[15:0]));
    return v;
  endfunction

  // captured port values
  logic c_en, c_wr, c_wb, c_upd;
  logic [31:0] c_addr, c_wdata, c_wbd, c_updd;
  logic [3:0] c_strb, c_wbi, c_updi;

  task automatic drive(bit st, int sz, bit u, int md, int rd, int bi,
                       logic [31:0] base, logic [31:0] src, logic [31:0] sp, int disp);
    req_valid = 1; req_store = st; req_size = 2'(sz); req_unsigned = u;
    req_mode = 2'(md); req_rd = 4'(rd); req_base_idx = 4'(bi);
    req_base = base; req_src = src; req_sp = sp; req_disp = 6'(disp);
  endtask

  task automatic run(bit st, int sz, bit u, int md, int rd, int bi,
                     logic [31:0] base, logic [31:0] src, logic [31:0] sp, int disp);
    @(negedge clk);
    drive(st, sz, u, md, rd, bi, base, src, sp, disp);
    #1;
    c_en = mem_en; c_wr = mem_wr; c_addr = mem_addr; c_strb = mem_wstrb; c_wdata = mem_wdata;
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
    c_wb = wb_en; c_wbi = wb_idx; c_wbd = wb_data;
    c_upd = upd_en; c_updi = upd_idx; c_updd = upd_data;
  endtask

  task automatic t_reset;
    chk("R12 mem_en", 32'(mem_en), 0);
    chk("R12 mem_wr", 32'(mem_wr), 0);
    chk("R12 strb", 32'(mem_wstrb), 0);
    chk("R12 wb_en", 32'(wb_en), 0);
    chk("R12 upd_en", 32'(upd_en), 0);
  endtask

  task automatic t_byte_load;
    bmem[4] = 32'h7F80_01FE;
    for (int lane = 0; lane < 4; lane++) begin
      run(0, 0, 0, 1, 3, 2, 32'h10 + lane, 0, 0, 0);
      chk("R1 signed byte", c_wbd, want_load(32'h10 + lane, 0, 0));
      chk("R8 indirect addr", c_addr, 32'h10 + lane);
      chk("R8 no update", 32'(c_upd), 0);
      run(0, 0, 1, 1, 3, 2, 32'h10 + lane, 0, 0, 0);
      chk("R2 unsigned byte", c_wbd, want_load(32'h10 + lane, 0, 1));
    end
  endtask

  task automatic t_half_load;
    bmem[5] = 32'h8001_7FFE;
    run(0, 1, 0, 1, 1, 2, 32'h14, 0, 0, 0);
    chk("R3 signed half lo", c_wbd, 32'h0000_7FFE);
    run(0, 1, 0, 1, 1, 2, 32'h16, 0, 0, 0);
    chk("R3 signed half hi", c_wbd, 32'hFFFF_8001);
    run(0, 1, 1, 1, 1, 2, 32'h16, 0, 0, 0);
    chk("R3 unsigned half hi", c_wbd, 32'h0000_8001);
  endtask

  task automatic t_word_load;
    bmem[6] = 32'h89AB_CDEF;
    run(0, 2, 1, 1, 7, 2, 32'h18, 0, 0, 0);
    chk("R5 word unsigned flag ignored", c_wbd, 32'h89AB_CDEF);
    chk("R5 wb idx", 32'(c_wbi), 7);
  endtask

  task automatic t_moves;
    run(1, 0, 0, 0, 9, 2, 32'h20, 32'h1234_56A5, 0, 0);
    chk("R4 move no mem", 32'(c_en), 0);
    chk("R4 move store flag ignored wb", 32'(c_wb), 1);
    chk("R4 signed byte move", c_wbd, want_move(32'h1234_56A5, 0, 0));
    run(0, 1, 1, 0, 9, 2, 0, 32'h1234_C5A5, 0, 0);
    chk("R4 unsigned half move", c_wbd, 32'h0000_C5A5);
    run(0, 1, 0, 0, 9, 2, 0, 32'h1234_C5A5, 0, 0);
    chk("R4 signed half move", c_wbd, 32'hFFFF_C5A5);
    run(0, 3, 1, 0, 9, 2, 0, 32'hDEAD_BEEF, 0, 0);
    chk("R5 word move", c_wbd, 32'hDEAD_BEEF);
  endtask

  task automatic t_post_inc;
    for (int sz = 0; sz < 3; sz++) begin
      run(0, sz, 0, 2, 1, 6, 32'h28, 0, 0, 0);
      chk("R6 old base used", c_addr, 32'h28);
      chk("R6 load data", c_wbd, want_load(32'h28, sz, 0));
      chk("R6 upd_en", 32'(c_upd), 1);
      chk("R6 upd idx", 32'(c_updi), 6);
      chk("R6 upd value", c_updd, 32'h28 + (1 << sz));
    end
  endtask

  task automatic t_stack_rel;
    run(0, 0, 1, 3, 2, 5, 32'h99, 0, 32'h40, 63);
    chk("R7 byte disp max", c_addr, 32'h7F);
    chk("R7 byte data", c_wbd, want_load(32'h7F, 0, 1));
    chk("R7 no update", 32'(c_upd), 0);
    run(0, 1, 0, 3, 2, 5, 32'h99, 0, 32'h40, 5);
    chk("R7 half scale", c_addr, 32'h4A);
    run(0, 2, 0, 3, 2, 5, 32'h99, 0, 32'h40, 3);
    chk("R7 word scale", c_addr, 32'h4C);
    chk("R7 word data", c_wbd, want_load(32'h4C, 2, 0));
  endtask

  task automatic t_stores;
    bmem[12] = 32'h1122_3344;
    run(1, 0, 0, 1, 4, 2, 32'h32, 32'hFFFF_FFAB, 0, 0);
    chk("R9 byte strobe", 32'(c_strb), 32'b0100);
    chk("R9 mem_wr", 32'(c_wr), 1);
    chk("R9 byte lane data", 32'(c_wdata[23:16]), 32'hAB);
    chk("R9 byte neighbours kept", bmem[12], 32'h11AB_3344);
    chk("R10 store no wb", 32'(c_wb), 0);
    run(1, 1, 0, 2, 4, 2, 32'h30, 32'h0000_BEEF, 0, 0);
    chk("R9 half strobe", 32'(c_strb), 32'b0011);
    chk("R9 half written", bmem[12], 32'h11AB_BEEF);
    chk("R6 store post update", c_updd, 32'h32);
    run(1, 1, 0, 1, 4, 2, 32'h32, 32'h0000_7788, 0, 0);
    chk("R9 half upper strobe", 32'(c_strb), 32'b1100);
    chk("R9 half upper written", bmem[12], 32'h7788_BEEF);
    run(1, 2, 0, 3, 4, 2, 0, 32'hCAFE_F00D, 32'h2C, 1);
    chk("R9 word strobe", 32'(c_strb), 32'b1111);
    chk("R9 word written", bmem[12], 32'hCAFE_F00D);
  endtask

  task automatic t_conflict;
    bmem[14] = 32'h0000_00C3;
    run(0, 0, 0, 2, 5, 5, 32'h38, 0, 0, 0);
    chk("R10 loaded data wins", c_wbd, 32'hFFFF_FFC3);
    chk("R10 wb idx", 32'(c_wbi), 5);
    chk("R10 update suppressed", 32'(c_upd), 0);
  endtask

  task automatic t_pipeline;
    logic [31:0] e1;
    bmem[15] = 32'h5566_7788;
    e1 = want_load(32'h3D, 0, 1);
    @(negedge clk);
    drive(0, 0, 1, 2, 1, 3, 32'h3D, 0, 0, 0);
    @(negedge clk);
    drive(0, 1, 0, 0, 2, 4, 0, 32'h0000_9001, 0, 0);
    @(negedge clk);
    req_valid = 0;
    chk("R11 first wb", wb_data, e1);
    chk("R11 first idx", 32'(wb_idx), 1);
    chk("R11 first upd", upd_data, 32'h3E);
    @(negedge clk);
    chk("R11 second wb", wb_data, 32'hFFFF_9001);
    chk("R11 second idx", 32'(wb_idx), 2);
    chk("R11 second no upd", 32'(upd_en), 0);
    @(negedge clk);
    chk("R11 quiet after", 32'(wb_en), 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) bmem[i] = (i * 32'h0103_0507) ^ 32'h8F17_E271;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_byte_load;
    t_half_load;
    t_word_load;
    t_moves;
    t_post_inc;
    t_stack_rel;
    t_stores;
    t_conflict;
    t_pipeline;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule